// File: doc/BRIEF.md
# Divider Configuration Port with Serial and Parallel Loading

This block holds the run-time settings of a clock synthesizer: a 9-bit feedback divide value, a 2-bit post-divide code and a 3-bit test-select code. The settings arrive over two independent paths that both run asynchronously to the core clock.

The parallel path carries a divide value, a post-divide code and a load strobe. While that strobe is low, the settings track the parallel inputs. The rising edge of the strobe freezes them. The serial path is three wires: a serial clock, serial data and a serial load strobe. Data moves into a 14-bit shift register. While the serial load strobe is high, the settings track that register, and the falling edge of the strobe freezes them. The parallel path always wins. The test-select code can be written only over the serial path.

All pins first pass through a common synchronizer into the core clock domain. The settings registers are updated there, so every downstream divider sees each new value in a single core-clock cycle. A tap shows the oldest stage of the shift register.

Top module: `cfgp_port`

## Requirements
- R1: After reset the divide value reads 0x1FF, the post-divide code reads 2'b11, the test-select code reads 3'b000 and the serial tap reads 0.
- R2: Each rising edge of the serial clock shifts the serial data bit into the register. The tap shows the bit sent 14 serial edges earlier.
- R3: A frame is 14 bits. The test-select code comes first (MSB first), then the post-divide code (MSB first), then the divide value (MSB first). After a full frame and a serial load pulse, the outputs equal those fields.
- R4: While the serial load strobe is high and the parallel strobe is high, the outputs follow the shift register. A further shift changes them.
- R5: While the serial load strobe is low and the parallel strobe is high, shifting does not change the outputs.
- R6: While the parallel strobe is low, the divide value and post-divide code follow the parallel inputs, and the test-select code reads 3'b000.
- R7: After the parallel strobe rises, later changes on the parallel inputs do not change the outputs.
- R8: While the parallel strobe is low, a serial load pulse has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_load | input | 1 | Parallel load strobe; low means transparent, rising edge captures |
| par_m | input | 9 | Parallel divide value |
| par_n | input | 2 | Parallel post-divide code |
| ser_clk | input | 1 | Serial shift clock |
| ser_din | input | 1 | Serial data |
| ser_load | input | 1 | Serial load strobe; high means transparent, falling edge captures |
| m_div | output | 9 | Held divide value |
| n_code | output | 2 | Held post-divide code |
| t_sel | output | 3 | Held test-select code |
| ser_tap | output | 1 | Oldest shift-register stage |

## Verification
The bench builds the block with three synchronizer stages instead of the default two. This lengthens every path from pin to register and shows that the bench's settle windows do not depend on exact latency. It steps the serial clock slowly against a bench-side model of the shift register. This covers shifting while transparent and while holding, and a serial load pulse that arrives while the parallel strobe is low.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
    localparam int M_W  = 9;
    localparam int N_W  = 2;
    localparam int T_W  = 3;
    localparam int FR_W = T_W + N_W + M_W;

    // packed MSB first: test code, post-divide code, divide value
    typedef struct packed {
        logic [T_W-1:0] t;
        logic [N_W-1:0] n;
        logic [M_W-1:0] m;
    } cfg_t;
endpackage

// File: rtl/cfgp_sync.sv
module cfgp_sync #(
    parameter int           W       = 1,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
        else        pipe_q <= pipe_d;
    end

    assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/cfgp_shift.sv
module cfgp_shift
    import cfgp_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sclk_s,
    input  logic            sdata_s,
    output logic [FR_W-1:0] shreg,
    output logic            sclk_rise
);
    typedef struct packed {
        logic [FR_W-1:0] sr;
        logic            sclk_prev;
    } sh_st_t;

    sh_st_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.sclk_prev = sclk_s;
        sclk_rise      = sclk_s & ~st_q.sclk_prev;
        if (sclk_rise) begin
            st_d.sr = {st_q.sr[FR_W-2:0], sdata_s};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign shreg = st_q.sr;
endmodule

// File: rtl/cfgp_latch.sv
module cfgp_latch
    import cfgp_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pload_s,
    input  logic            sload_s,
    input  logic [M_W-1:0]  par_m_s,
    input  logic [N_W-1:0]  par_n_s,
    input  logic [FR_W-1:0] shreg,
    output cfg_t            cfg
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (!pload_s) begin
            // parallel path wins; test code is not reachable from it
            cfg_d.m = par_m_s;
            cfg_d.n = par_n_s;
            cfg_d.t = '0;
        end else if (sload_s) begin
            cfg_d = cfg_t'(shreg);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.m <= '1;
            cfg_q.n <= '1;
            cfg_q.t <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/cfgp_port.sv
module cfgp_port
    import cfgp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           par_load,
    input  logic [M_W-1:0] par_m,
    input  logic [N_W-1:0] par_n,
    input  logic           ser_clk,
    input  logic           ser_din,
    input  logic           ser_load,
    output logic [M_W-1:0] m_div,
    output logic [N_W-1:0] n_code,
    output logic [T_W-1:0] t_sel,
    output logic           ser_tap
);
    localparam int SW = 4 + N_W + M_W;
    localparam logic [SW-1:0] SYNC_RST = {1'b1, 1'b0, 1'b0, 1'b0, {N_W{1'b1}}, {M_W{1'b1}}};

    logic [SW-1:0]   raw, synced;
    logic            pload_s, sload_s, sclk_s, sdata_s;
    logic [N_W-1:0]  par_n_s;
    logic [M_W-1:0]  par_m_s;
    logic [FR_W-1:0] shreg;
    logic            sclk_rise;
    cfg_t            cfg;

    assign raw = {par_load, ser_load, ser_clk, ser_din, par_n, par_m};

    cfgp_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw), .q(synced)
    );

    assign {pload_s, sload_s, sclk_s, sdata_s, par_n_s, par_m_s} = synced;

    cfgp_shift u_shift (
        .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .sdata_s(sdata_s),
        .shreg(shreg), .sclk_rise(sclk_rise)
    );

    cfgp_latch u_latch (
        .clk(clk), .rst_n(rst_n), .pload_s(pload_s), .sload_s(sload_s),
        .par_m_s(par_m_s), .par_n_s(par_n_s), .shreg(shreg), .cfg(cfg)
    );

    assign m_div   = cfg.m;
    assign n_code  = cfg.n;
    assign t_sel   = cfg.t;
    assign ser_tap = shreg[FR_W-1];
endmodule

// File: rtl/cfgp_checker.sv
module cfgp_checker
    import cfgp_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            pload_s,
    input logic            sload_s,
    input logic            sclk_rise,
    input logic            sdata_s,
    input logic [M_W-1:0]  par_m_s,
    input logic [N_W-1:0]  par_n_s,
    input logic [FR_W-1:0] shreg,
    input logic [M_W-1:0]  m_div,
    input logic [N_W-1:0]  n_code,
    input logic [T_W-1:0]  t_sel,
    input logic            ser_tap
);
    p_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_rise |=> shreg == {$past(shreg[FR_W-2:0]), $past(sdata_s)});

    p_tap_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_rise |=> $stable(ser_tap));

    p_follow_ser_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pload_s && sload_s) |=> {t_sel, n_code, m_div} == $past(shreg));

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pload_s && !sload_s) |=> $stable({t_sel, n_code, m_div}));

    p_follow_par_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !pload_s |=> (m_div == $past(par_m_s)) && (n_code == $past(par_n_s)));

    p_t_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !pload_s |=> t_sel == '0);
endmodule

bind cfgp_port cfgp_checker u_chk (
    .clk(clk), .rst_n(rst_n), .pload_s(pload_s), .sload_s(sload_s),
    .sclk_rise(sclk_rise), .sdata_s(sdata_s), .par_m_s(par_m_s),
    .par_n_s(par_n_s), .shreg(shreg), .m_div(m_div), .n_code(n_code),
    .t_sel(t_sel), .ser_tap(ser_tap)
);

// File: tb/cfgp_port_bench.sv
module cfgp_port_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       par_load = 1'b1;
    logic [8:0] par_m = 9'h1FF;
    logic [1:0] par_n = 2'b11;
    logic       ser_clk = 1'b0;
    logic       ser_din = 1'b0;
    logic       ser_load = 1'b0;
    logic [8:0] m_div;
    logic [1:0] n_code;
    logic [2:0] t_sel;
    logic       ser_tap;

    int n_vec = 0;
    int n_bad = 0;
    logic [13:0] sr_model = '0;
    logic [13:0] held;

    always #4 clk = ~clk;

    cfgp_port #(.SYNC_STAGES(3)) u_cfgp_port (
        .clk(clk), .rst_n(rst_n), .par_load(par_load), .par_m(par_m),
        .par_n(par_n), .ser_clk(ser_clk), .ser_din(ser_din),
        .ser_load(ser_load), .m_div(m_div), .n_code(n_code),
        .t_sel(t_sel), .ser_tap(ser_tap)
    );

    task automatic settle();
        repeat (8) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic ser_bit(input logic b);
        ser_din = b;
        settle();
        ser_clk = 1'b1;
        settle();
        ser_clk = 1'b0;
        settle();
        sr_model = {sr_model[12:0], b};
    endtask

    task automatic send_frame(input logic [13:0] fr);
        for (int i = 13; i >= 0; i--) ser_bit(fr[i]);
    endtask

    task automatic t_reset();
        chk("R1 m", 16'(m_div), 16'h1FF);
        chk("R1 n", 16'(n_code), 16'h3);
        chk("R1 t", 16'(t_sel), 16'h0);
        chk("R1 tap", 16'(ser_tap), 16'h0);
    endtask

    task automatic t_parallel();
        par_m = 9'h0C8; par_n = 2'b01; par_load = 1'b0;
        settle();
        chk("R6 m", 16'(m_div), 16'h0C8);
        chk("R6 n", 16'(n_code), 16'h1);
        chk("R6 t", 16'(t_sel), 16'h0);
        par_m = 9'h105; par_n = 2'b10;
        settle();
        chk("R6 m track", 16'(m_div), 16'h105);
        par_load = 1'b1;
        settle();
        par_m = 9'h0AA; par_n = 2'b00;
        settle();
        chk("R7 m hold", 16'(m_div), 16'h105);
        chk("R7 n hold", 16'(n_code), 16'h2);
    endtask

    task automatic t_serial();
        logic [13:0] fr;
        fr = {3'b101, 2'b10, 9'h14F};
        send_frame(fr);
        chk("R2 tap first bit", 16'(ser_tap), 16'(fr[13]));
        chk("R5 no load yet", 16'(m_div), 16'h105);
        ser_load = 1'b1; settle();
        ser_load = 1'b0; settle();
        chk("R3 t", 16'(t_sel), 16'h5);
        chk("R3 n", 16'(n_code), 16'h2);
        chk("R3 m", 16'(m_div), 16'h14F);
        ser_bit(1'b0);
        chk("R2 tap second bit", 16'(ser_tap), 16'(fr[12]));
        chk("R5 hold", 16'({t_sel, n_code, m_div}), 16'(fr));
    endtask

    task automatic t_transparent();
        ser_load = 1'b1; settle();
        chk("R4 follow", 16'({t_sel, n_code, m_div}), 16'(sr_model));
        ser_bit(1'b1);
        chk("R4 follow shift", 16'({t_sel, n_code, m_div}), 16'(sr_model));
        ser_load = 1'b0; settle();
        held = sr_model;
        ser_bit(1'b1);
        chk("R5 hold after fall", 16'({t_sel, n_code, m_div}), 16'(held));
    endtask

    task automatic t_priority();
        par_m = 9'h123; par_n = 2'b10; par_load = 1'b0;
        settle();
        ser_load = 1'b1;
        send_frame({3'b111, 2'b01, 9'h0F0});
        chk("R8 m", 16'(m_div), 16'h123);
        chk("R8 n", 16'(n_code), 16'h2);
        chk("R8 t", 16'(t_sel), 16'h0);
        ser_load = 1'b0; settle();
        par_load = 1'b1; settle();
        par_m = 9'h001; settle();
        chk("R7 after priority", 16'(m_div), 16'h123);
    endtask

    initial begin
        fork
            begin
                repeat (5) @(posedge clk);
                @(negedge clk);
                rst_n = 1'b1;
                settle();
                t_reset();
                t_parallel();
                t_serial();
                t_transparent();
                t_priority();
            end
            begin
                repeat (150000) @(posedge clk);
                n_vec++;
                n_bad++;
                $display("FAIL watchdog actual=running expected=done");
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule